// File: doc/BRIEF.md
# DMA Request Routing Slot

This block is one routing slot between a wide set of peripheral request lines and a single request input of a DMA engine. A 32-bit configuration word selects one of up to 128 request lines and sets one of several operating modes. In the simplest mode the chosen line is passed straight through. In the other modes the request is held off until a periodic trigger pulse arrives, or it is raised permanently with no source at all.

The configuration word is written and read back through a plain write port and a read bus. While the slot is enabled, the source and trigger fields are locked. Only some slots in a system can use the periodic trigger: a parameter gives the slot's own index and the number of slots that have a trigger. On a slot without one, the trigger control reads back as 0 and has no effect.

In the modes that use the trigger, a pulse sets an internal arm flag. An acknowledge from the DMA engine clears that flag again.

Top module: `dmux_slot`

## Requirements
- R1: After reset the configuration word reads 0x0000_0000 and the request output is low.
- R2: When the enable bit (bit 31) is 0, the request output is low, whatever the trigger bit (bit 30), the always-on bit (bit 29) and the request lines hold.
- R3: With enable=1, trigger=0 and always-on=0, the request output follows the request line numbered by the source field (bits 6:0) in the same cycle.
- R4: A source field of 0 selects no line, so the output stays low in pass-through mode and in trigger-gated mode.
- R5: With enable=1, trigger=1 and always-on=0, a high trigger input at a clock edge arms the slot from the next cycle on. While the slot is armed, the output equals the selected request line. A high acknowledge at a clock edge disarms the slot.
- R6: With enable=1, always-on=1 and trigger=0, the output is high whatever the source field and the request lines hold.
- R7: With enable=1, always-on=1 and trigger=1, the output is low until a trigger pulse arms the slot. It then stays high, whatever the request lines hold, until an acknowledge disarms it.
- R8: On a slot whose index is not below the number of trigger-capable slots, the trigger bit reads back as 0 and a write of 1 to it gives pass-through behaviour.
- R9: A write whose bit 31 is 1, made while the slot is already enabled, leaves the trigger and source fields unchanged. It still updates the always-on bit.
- R10: A write made while the slot is disabled, or a write that clears bit 31, stores the enable, trigger, always-on and source fields in full.
- R11: Only bits 31, 30, 29 and 6:0 are stored. All other bits of the configuration word read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word |
| src_req | input | 128 | Peripheral request lines; line 0 is unused |
| trig_pulse | input | 1 | Periodic trigger pulse |
| dma_ack | input | 1 | Acknowledge from the DMA engine; disarms the slot |
| dma_req | output | 1 | Request to the DMA engine |

## Verification
The assertions take for granted that the request lines, trigger and acknowledge are synchronous to `clk` and are stable around each rising edge. They also assume an acknowledge comes only while the slot is in a mode that uses the trigger. The stimulus changes every input just after a falling edge and checks outputs either shortly after that change or at the next falling edge. Acknowledges are driven only in the trigger-gated modes. Every mode change passes through a write with the enable bit at 0, as the lock rules require.

// File: rtl/dmux_pkg.sv
package dmux_pkg;
   localparam int CFG_W     = 32;
   localparam int EN_BIT    = 31;
   localparam int TRIG_BIT  = 30;
   localparam int AON_BIT   = 29;
   localparam int SRC_LSB   = 0;

   typedef enum logic [2:0] {
      MODE_OFF,
      MODE_PASS,
      MODE_GATED,
      MODE_HOLD,
      MODE_HOLD_TRIG
   } slot_mode_e;

   function automatic slot_mode_e decode_mode(input logic en, input logic trig, input logic aon);
      if (!en)             return MODE_OFF;
      else if (aon && trig) return MODE_HOLD_TRIG;
      else if (aon)         return MODE_HOLD;
      else if (trig)        return MODE_GATED;
      else                  return MODE_PASS;
   endfunction
endpackage

// File: rtl/dmux_cfg_reg.sv
module dmux_cfg_reg #(
   parameter int SEL_W    = 7,
   parameter bit HAS_TRIG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [31:0]      wdata,
   output logic             en_q,
   output logic             trig_q,
   output logic             aon_q,
   output logic [SEL_W-1:0] src_q
);
   import dmux_pkg::*;

   logic full_write;
   logic trig_in;

   // fields may all change unless the slot stays enabled across the write
   assign full_write = !en_q || !wdata[EN_BIT];

   generate
      if (HAS_TRIG) begin : g_trig
         assign trig_in = wdata[TRIG_BIT];
      end else begin : g_no_trig
         assign trig_in = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         trig_q <= 1'b0;
         aon_q  <= 1'b0;
         src_q  <= '0;
      end else if (we) begin
         en_q  <= wdata[EN_BIT];
         aon_q <= wdata[AON_BIT];
         if (full_write) begin
            trig_q <= trig_in;
            src_q  <= wdata[SRC_LSB +: SEL_W];
         end
      end
   end
endmodule

// File: rtl/dmux_src_sel.sv
module dmux_src_sel #(
   parameter int NUM_SRC = 128,
   parameter int SEL_W   = 7
) (
   input  logic [NUM_SRC-1:0] lines,
   input  logic [SEL_W-1:0]   sel,
   output logic               hit
);
   logic [NUM_SRC-1:0] onehot;

   // line 0 is the "nothing connected" code
   assign onehot[0] = 1'b0;
   generate
      for (genvar i = 1; i < NUM_SRC; i++) begin : g_dec
         assign onehot[i] = (sel == SEL_W'(i)) && lines[i];
      end
   endgenerate

   assign hit = |onehot;
endmodule

// File: rtl/dmux_req_gen.sv
module dmux_req_gen (
   input  logic               clk,
   input  logic               rst_n,
   input  dmux_pkg::slot_mode_e mode,
   input  logic               sel_hit,
   input  logic               trig_pulse,
   input  logic               ack,
   output logic               req
);
   import dmux_pkg::*;

   logic armed_q;
   logic uses_trig;

   assign uses_trig = (mode == MODE_GATED) || (mode == MODE_HOLD_TRIG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  armed_q <= 1'b0;
      else if (!uses_trig)         armed_q <= 1'b0;
      else if (trig_pulse)         armed_q <= 1'b1;
      else if (ack)                armed_q <= 1'b0;
   end

   always_comb begin
      unique case (mode)
         MODE_PASS:      req = sel_hit;
         MODE_GATED:     req = armed_q && sel_hit;
         MODE_HOLD:      req = 1'b1;
         MODE_HOLD_TRIG: req = armed_q;
         default:        req = 1'b0;
      endcase
   end
endmodule

// File: rtl/dmux_slot.sv
module dmux_slot #(
   parameter int NUM_SRC    = 128,
   parameter int SEL_W      = 7,
   parameter int CHAN_IDX   = 0,
   parameter int TRIG_CHANS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               trig_pulse,
   input  logic               dma_ack,
   output logic               dma_req
);
   import dmux_pkg::*;

   localparam bit HAS_TRIG = (CHAN_IDX < TRIG_CHANS);

   initial begin
      if (NUM_SRC < 2 || NUM_SRC > (1 << SEL_W))
         $error("dmux_slot: NUM_SRC must fit the source field");
      if (SEL_W > AON_BIT)
         $error("dmux_slot: source field overlaps control bits");
   end

   logic             en_q, trig_q, aon_q;
   logic [SEL_W-1:0] src_q;
   logic             hit;
   slot_mode_e       mode;

   dmux_cfg_reg #(.SEL_W(SEL_W), .HAS_TRIG(HAS_TRIG)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .en_q(en_q), .trig_q(trig_q), .aon_q(aon_q), .src_q(src_q)
   );

   dmux_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .lines(src_req), .sel(src_q), .hit(hit)
   );

   assign mode = decode_mode(en_q, trig_q, aon_q);

   dmux_req_gen u_gen (
      .clk(clk), .rst_n(rst_n), .mode(mode), .sel_hit(hit),
      .trig_pulse(trig_pulse), .ack(dma_ack), .req(dma_req)
   );

   always_comb begin
      cfg_rdata                     = '0;
      cfg_rdata[EN_BIT]             = en_q;
      cfg_rdata[TRIG_BIT]           = trig_q;
      cfg_rdata[AON_BIT]            = aon_q;
      cfg_rdata[SRC_LSB +: SEL_W]   = src_q;
   end
endmodule

// File: rtl/dmux_slot_chk.sv
module dmux_slot_chk #(
   parameter int NUM_SRC    = 128,
   parameter int SEL_W      = 7,
   parameter int CHAN_IDX   = 0,
   parameter int TRIG_CHANS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [31:0]        cfg_wdata,
   input logic [31:0]        cfg_rdata,
   input logic [NUM_SRC-1:0] src_req,
   input logic               trig_pulse,
   input logic               dma_req
);
   logic [SEL_W-1:0] sel;
   logic             sel_line;
   assign sel      = cfg_rdata[SEL_W-1:0];
   assign sel_line = (sel != '0) && src_req[sel];

   // R2
   disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[31] |-> !dma_req);

   // R3
   pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[31:29] == 3'b100) |-> (dma_req == sel_line));

   // R4
   no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[31] && !cfg_rdata[29] && sel == '0) |-> !dma_req);

   // R5
   gated_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[31:29] == 3'b110 && dma_req) |-> sel_line);

   // R6
   hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[31:29] == 3'b101) |-> dma_req);

   // R9
   locked_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[31] && cfg_we && cfg_wdata[31]) |=>
         ($stable(cfg_rdata[30]) && $stable(cfg_rdata[SEL_W-1:0])));

   // R11
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[28:SEL_W] == '0);

   generate
      if (CHAN_IDX >= TRIG_CHANS) begin : g_notrig
         // R8
         no_trig_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_rdata[30]);
      end
   endgenerate
endmodule

bind dmux_slot dmux_slot_chk #(
   .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .CHAN_IDX(CHAN_IDX), .TRIG_CHANS(TRIG_CHANS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
   .cfg_rdata(cfg_rdata), .src_req(src_req), .trig_pulse(trig_pulse),
   .dma_req(dma_req)
);

// File: tb/dmux_slot_tb.sv
`timescale 1ns/1ps
module dmux_slot_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         we = 1'b0, we_hi = 1'b0;
   logic [31:0]  wdata = '0, wdata_hi = '0;
   logic [31:0]  rdata, rdata_hi;
   logic [127:0] lines = '0;
   logic         trig = 1'b0;
   logic         ack = 1'b0;
   logic         req, req_hi;
   int           errors = 0;
   int           checks = 0;
   bit           done = 1'b0;

   always #2 clk = ~clk;

   dmux_slot u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata), .cfg_rdata(rdata),
      .src_req(lines), .trig_pulse(trig), .dma_ack(ack), .dma_req(req)
   );

   dmux_slot #(.CHAN_IDX(6)) u_dut_hi (
      .clk(clk), .rst_n(rst_n), .cfg_we(we_hi), .cfg_wdata(wdata_hi), .cfg_rdata(rdata_hi),
      .src_req(lines), .trig_pulse(trig), .dma_ack(ack), .dma_req(req_hi)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); we = 1'b1; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic wr_hi(input logic [31:0] d);
      @(negedge clk); we_hi = 1'b1; wdata_hi = d;
      @(negedge clk); we_hi = 1'b0;
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic set_lines(input logic [127:0] v);
      @(negedge clk); lines = v; #1;
   endtask

   task automatic t_reset();
      check("R1 rdata", rdata, 32'h0);
      check("R1 req", {31'b0, req}, 32'h0);
   endtask

   task automatic t_disabled();
      wr(32'h6000_0005);
      set_lines('1);
      check("R2 disabled req", {31'b0, req}, 32'h0);
      pulse_trig(); #1;
      check("R2 disabled after trig", {31'b0, req}, 32'h0);
      set_lines('0);
   endtask

   task automatic t_normal();
      wr(32'h0);
      wr(32'h8000_0005);
      set_lines(128'h20);
      check("R3 line5 high", {31'b0, req}, 32'h1);
      set_lines(128'h40);
      check("R3 other line", {31'b0, req}, 32'h0);
      wr(32'h0); wr(32'h8000_007F);
      set_lines({1'b1, 127'b0});
      check("R3 line127", {31'b0, req}, 32'h1);
      wr(32'h0); wr(32'h8000_0000);
      set_lines('1);
      check("R4 source0 pass", {31'b0, req}, 32'h0);
      set_lines('0);
   endtask

   task automatic t_periodic();
      wr(32'h0);
      wr(32'hC000_0005);
      set_lines(128'h20);
      check("R5 unarmed", {31'b0, req}, 32'h0);
      pulse_trig(); #1;
      check("R5 armed", {31'b0, req}, 32'h1);
      set_lines('0);
      check("R5 armed line low", {31'b0, req}, 32'h0);
      set_lines(128'h20);
      check("R5 still armed", {31'b0, req}, 32'h1);
      pulse_ack(); #1;
      check("R5 ack disarms", {31'b0, req}, 32'h0);
      wr(32'h0); wr(32'hC000_0000);
      pulse_trig();
      set_lines('1);
      check("R4 source0 gated", {31'b0, req}, 32'h0);
      set_lines('0);
   endtask

   task automatic t_always();
      wr(32'h0);
      wr(32'hA000_0000);
      #1;
      check("R6 hold no lines", {31'b0, req}, 32'h1);
      wr(32'h0);
      wr(32'hE000_0009);
      #1;
      check("R7 before trig", {31'b0, req}, 32'h0);
      pulse_trig(); #1;
      check("R7 after trig", {31'b0, req}, 32'h1);
      repeat (3) @(negedge clk);
      #1;
      check("R7 held", {31'b0, req}, 32'h1);
      pulse_ack(); #1;
      check("R7 ack clears", {31'b0, req}, 32'h0);
   endtask

   task automatic t_lock();
      wr(32'h0);
      wr(32'h8000_0005);
      wr(32'hC000_0009);
      check("R9 locked", rdata, 32'h8000_0005);
      wr(32'hA000_0009);
      check("R9 aon updates", rdata, 32'hA000_0005);
      wr(32'h4000_0009);
      check("R10 clear enable", rdata, 32'h4000_0009);
      wr(32'hC000_0011);
      check("R10 from disabled", rdata, 32'hC000_0011);
      wr(32'h0);
      wr(32'hFFFF_FFFF);
      check("R11 unused bits", rdata, 32'hE000_007F);
      wr(32'h0);
   endtask

   task automatic t_no_trig_slot();
      wr_hi(32'hC000_0003);
      check("R8 trig reads 0", rdata_hi, 32'h8000_0003);
      set_lines(128'h8);
      check("R8 passes through", {31'b0, req_hi}, 32'h1);
      set_lines('0);
      check("R8 follows line", {31'b0, req_hi}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_disabled();
      t_normal();
      t_periodic();
      t_always();
      t_lock();
      t_no_trig_slot();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule